// File: doc/BRIEF.md
# Block-Atomic Instruction Window Controller

This controller keeps the books for a processor that fetches, executes and retires code in multi-instruction blocks rather than one instruction at a time. It holds a small ring of window slots, up to eight by default. Each fetched block takes one slot. The execution side reports a block as complete by pulsing that slot's completion line. The controller then retires the oldest block of each thread, one block per cycle. On a misprediction it discards every block younger than the named one. Fetch, execution and retirement of different blocks overlap, and each block may take any number of cycles to complete.

There are two modes. In single-thread mode, thread 0 owns all eight slots as one circular ring, and only one block in the ring is non-speculative. In multithreaded mode, the slots are split into four private rings of two, one ring per thread. The mode register is loaded only while the window is empty, so slot ownership never changes under a block that is in flight.

Top module: `blockWindow`

## Requirements
- R1: After reset the window is empty and in single-thread mode, `commitValid` is low, and the first fetch from thread 0 is granted slot 0.
- R2: In single-thread mode (`mtMode` loaded as 0), only thread 0 is granted. Its blocks take slots 0,1,...,7,0,... in circular order. A request carrying any other thread identifier is refused.
- R3: In multithreaded mode (loaded as 1), thread t owns slots 2t and 2t+1 and takes them alternately, starting from 2t.
- R4: `fetchGrant` rises in the same cycle as `fetchReq` only when the requesting thread's ring holds fewer blocks than the ring size. A slot cannot be reused until its previous block has retired. `fetchSlot` gives the slot taken.
- R5: A pulse on `doneIn[s]` is remembered only while slot s holds a block. A pulse on an empty slot is ignored and does not mark a block fetched into that slot later.
- R6: A thread's oldest block retires in the cycle after its completion has been recorded, and never before an older block of the same thread. `commitValid` is high for exactly one cycle per block, with `commitSlot` and `commitTid`.
- R7: When several threads have a retirable oldest block, the lowest thread identifier retires first. Only one block retires per cycle.
- R8: A flush naming an occupied slot N removes every younger block of N's thread at that clock edge. N and older blocks stay, other threads are untouched, and that thread's next fetch takes the slot after N. A flush naming an empty slot has no effect.
- R9: In a cycle with `flushReq` high, no fetch is granted and no block retires.
- R10: `modeReq` is loaded at an edge only when no slot is occupied and `fetchReq` is low. At any other time it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeReq | input | 1 | Requested mode: 0 single-thread, 1 multithreaded |
| fetchReq | input | 1 | Request a slot for a newly fetched block |
| fetchTid | input | 2 | Thread identifier of the request |
| fetchGrant | output | 1 | Request accepted this cycle |
| fetchSlot | output | 3 | Slot given to the block |
| doneIn | input | 8 | Per-slot completion pulse |
| flushReq | input | 1 | Misprediction: discard blocks younger than `flushSlot` |
| flushSlot | input | 3 | Slot of the last correct block |
| commitValid | output | 1 | One-cycle retire pulse |
| commitSlot | output | 3 | Slot being retired |
| commitTid | output | 2 | Thread of the retired block |

## Verification
A random phase mixes grants, sparse completion pulses, occasional flushes and periodic mode switches. Directed runs target specific orderings. Completion of a younger block ahead of the oldest distinguishes in-order retirement from first-done retirement. Completions on several threads in the same cycle expose the priority order. A flush into the middle of a full ring, and a flush that lands together with a fetch, show whether younger blocks are dropped and the fetch pointer is rewound. Mode requests made while blocks are in flight, and a completion pulse on an empty slot, check that both inputs are ignored.

// File: rtl/bw_pkg.sv
`timescale 1ns/1ps
package bwPkg;
  localparam int WIN_SLOTS   = 8;
  localparam int WIN_THREADS = 4;
  localparam int SLOT_W      = $clog2(WIN_SLOTS);
  localparam int TID_W       = $clog2(WIN_THREADS);

  typedef struct packed {
    logic              allocEn;
    logic [TID_W-1:0]  allocTid;
    logic [SLOT_W-1:0] allocSlot;
    logic              commitEn;
    logic [TID_W-1:0]  commitTid;
    logic [SLOT_W-1:0] commitSlot;
    logic              flushEn;
    logic [TID_W-1:0]  flushTid;
    logic [SLOT_W-1:0] flushIdx;
    logic              modeLoad;
    logic              modeVal;
  } bwStrobes_t;
endpackage

// File: rtl/bw_ctrl.sv
`timescale 1ns/1ps
module bwCtrl
  import bwPkg::*;
#(
  parameter int NUM_SLOTS   = WIN_SLOTS,
  parameter int NUM_THREADS = WIN_THREADS
) (
  input  logic                                 mtMode,
  input  logic [NUM_SLOTS-1:0]                 slotValid,
  input  logic [NUM_SLOTS-1:0]                 slotDone,
  input  logic [NUM_THREADS-1:0][SLOT_W-1:0]   headIdx,
  input  logic [NUM_THREADS-1:0][SLOT_W-1:0]   tailIdx,
  input  logic [NUM_THREADS-1:0][SLOT_W:0]     occCnt,
  input  logic                                 fetchReq,
  input  logic [TID_W-1:0]                     fetchTid,
  input  logic                                 flushReq,
  input  logic [SLOT_W-1:0]                    flushSlot,
  input  logic                                 modeReq,
  output logic                                 fetchGrant,
  output logic [SLOT_W-1:0]                    fetchSlot,
  output logic                                 commitValid,
  output logic [SLOT_W-1:0]                    commitSlot,
  output logic [TID_W-1:0]                     commitTid,
  output bwStrobes_t                           strobes
);
  localparam int MT_RING  = NUM_SLOTS / NUM_THREADS;
  localparam int MT_SHIFT = $clog2(MT_RING);

  logic [SLOT_W:0]   ringSize;
  logic [SLOT_W-1:0] ringMask;
  logic [SLOT_W-1:0] fetchBase;
  logic              tidOk;
  logic              ringFree;
  logic [NUM_THREADS-1:0][SLOT_W-1:0] headSlot;
  logic [NUM_THREADS-1:0]             headReady;
  logic              commitAny;
  logic [SLOT_W-1:0] pickSlot;
  logic [TID_W-1:0]  pickTid;
  logic              flushHit;
  logic              windowEmpty;

  assign ringSize = mtMode ? (SLOT_W+1)'(MT_RING) : (SLOT_W+1)'(NUM_SLOTS);
  assign ringMask = ringSize[SLOT_W-1:0] - SLOT_W'(1);

  // fetch side: per-thread ring base, occupancy check
  assign fetchBase  = mtMode ? SLOT_W'(fetchTid) << MT_SHIFT : '0;
  assign tidOk      = mtMode || (fetchTid == '0);
  assign ringFree   = occCnt[fetchTid] < ringSize;
  assign fetchGrant = fetchReq && tidOk && ringFree && !flushReq;
  assign fetchSlot  = fetchBase + tailIdx[fetchTid];

  // retire side: oldest block of every thread, lowest thread wins
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_head
    assign headSlot[t]  = (mtMode ? SLOT_W'(t * MT_RING) : '0) + headIdx[t];
    assign headReady[t] = (occCnt[t] != '0) && slotDone[headSlot[t]];
  end

  always_comb begin
    commitAny = 1'b0;
    pickSlot  = '0;
    pickTid   = '0;
    for (int t = NUM_THREADS - 1; t >= 0; t--) begin
      if (headReady[t]) begin
        commitAny = 1'b1;
        pickSlot  = headSlot[t];
        pickTid   = TID_W'(t);
      end
    end
  end

  assign commitValid = commitAny && !flushReq;
  assign commitSlot  = pickSlot;
  assign commitTid   = pickTid;

  // flush decode and mode sampling
  assign flushHit    = flushReq && slotValid[flushSlot];
  assign windowEmpty = ~|slotValid;

  always_comb begin
    strobes            = '0;
    strobes.allocEn    = fetchGrant;
    strobes.allocTid   = fetchTid;
    strobes.allocSlot  = fetchSlot;
    strobes.commitEn   = commitValid;
    strobes.commitTid  = pickTid;
    strobes.commitSlot = pickSlot;
    strobes.flushEn    = flushHit;
    strobes.flushTid   = mtMode ? TID_W'(flushSlot >> MT_SHIFT) : '0;
    strobes.flushIdx   = flushSlot & ringMask;
    strobes.modeLoad   = windowEmpty && !fetchReq && (modeReq != mtMode);
    strobes.modeVal    = modeReq;
  end
endmodule

// File: rtl/bw_data.sv
`timescale 1ns/1ps
module bwData
  import bwPkg::*;
#(
  parameter int NUM_SLOTS   = WIN_SLOTS,
  parameter int NUM_THREADS = WIN_THREADS
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  bwStrobes_t                           strobes,
  input  logic [NUM_SLOTS-1:0]                 doneIn,
  output logic                                 mtMode,
  output logic [NUM_SLOTS-1:0]                 slotValid,
  output logic [NUM_SLOTS-1:0]                 slotDone,
  output logic [NUM_THREADS-1:0][SLOT_W-1:0]   headIdx,
  output logic [NUM_THREADS-1:0][SLOT_W-1:0]   tailIdx,
  output logic [NUM_THREADS-1:0][SLOT_W:0]     occCnt
);
  localparam int MT_RING  = NUM_SLOTS / NUM_THREADS;
  localparam int MT_SHIFT = $clog2(MT_RING);

  logic [SLOT_W:0]   ringSize;
  logic [SLOT_W-1:0] ringMask;

  assign ringSize = mtMode ? (SLOT_W+1)'(MT_RING) : (SLOT_W+1)'(NUM_SLOTS);
  assign ringMask = ringSize[SLOT_W-1:0] - SLOT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN)                 mtMode <= 1'b0;
    else if (strobes.modeLoad) mtMode <= strobes.modeVal;
  end

  // per-thread ring pointers
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic isAlloc, isCommit, isFlush;
    logic [SLOT_W-1:0] keepDist;
    assign isAlloc  = strobes.allocEn  && (strobes.allocTid  == TID_W'(t));
    assign isCommit = strobes.commitEn && (strobes.commitTid == TID_W'(t));
    assign isFlush  = strobes.flushEn  && (strobes.flushTid  == TID_W'(t));
    assign keepDist = (strobes.flushIdx - headIdx[t]) & ringMask;

    always_ff @(posedge clk) begin
      if (!rstN || strobes.modeLoad) begin
        headIdx[t] <= '0;
        tailIdx[t] <= '0;
        occCnt[t]  <= '0;
      end else if (isFlush) begin
        tailIdx[t] <= (strobes.flushIdx + SLOT_W'(1)) & ringMask;
        occCnt[t]  <= {1'b0, keepDist} + (SLOT_W+1)'(1);
      end else begin
        if (isAlloc)  tailIdx[t] <= (tailIdx[t] + SLOT_W'(1)) & ringMask;
        if (isCommit) headIdx[t] <= (headIdx[t] + SLOT_W'(1)) & ringMask;
        case ({isAlloc, isCommit})
          2'b10:   occCnt[t] <= occCnt[t] + (SLOT_W+1)'(1);
          2'b01:   occCnt[t] <= occCnt[t] - (SLOT_W+1)'(1);
          default: occCnt[t] <= occCnt[t];
        endcase
      end
    end
  end

  // per-slot occupancy and completion bits
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [TID_W-1:0]  ownTid;
    logic [SLOT_W-1:0] localIdx;
    logic [SLOT_W-1:0] myAge;
    logic [SLOT_W-1:0] keepAge;
    logic              killed;
    logic              retired;
    logic              filled;

    assign ownTid   = mtMode ? TID_W'(s >> MT_SHIFT) : '0;
    assign localIdx = SLOT_W'(s) & ringMask;
    assign myAge    = (localIdx - headIdx[ownTid]) & ringMask;
    assign keepAge  = (strobes.flushIdx - headIdx[ownTid]) & ringMask;
    assign killed   = strobes.flushEn && (strobes.flushTid == ownTid)
                      && slotValid[s] && (myAge > keepAge);
    assign retired  = strobes.commitEn && (strobes.commitSlot == SLOT_W'(s));
    assign filled   = strobes.allocEn  && (strobes.allocSlot  == SLOT_W'(s));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[s] <= 1'b0;
        slotDone[s]  <= 1'b0;
      end else if (killed || retired) begin
        slotValid[s] <= 1'b0;
        slotDone[s]  <= 1'b0;
      end else if (filled) begin
        slotValid[s] <= 1'b1;
        slotDone[s]  <= 1'b0;
      end else if (doneIn[s] && slotValid[s]) begin
        slotDone[s]  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/block_window.sv
`timescale 1ns/1ps
module blockWindow
  import bwPkg::*;
#(
  parameter int NUM_SLOTS   = WIN_SLOTS,
  parameter int NUM_THREADS = WIN_THREADS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeReq,
  input  logic              fetchReq,
  input  logic [TID_W-1:0]  fetchTid,
  output logic              fetchGrant,
  output logic [SLOT_W-1:0] fetchSlot,
  input  logic [NUM_SLOTS-1:0] doneIn,
  input  logic              flushReq,
  input  logic [SLOT_W-1:0] flushSlot,
  output logic              commitValid,
  output logic [SLOT_W-1:0] commitSlot,
  output logic [TID_W-1:0]  commitTid
);
  bwStrobes_t strobes;
  logic mtMode;
  logic [NUM_SLOTS-1:0] slotValid;
  logic [NUM_SLOTS-1:0] slotDone;
  logic [NUM_THREADS-1:0][SLOT_W-1:0] headIdx;
  logic [NUM_THREADS-1:0][SLOT_W-1:0] tailIdx;
  logic [NUM_THREADS-1:0][SLOT_W:0]   occCnt;

  bwCtrl #(.NUM_SLOTS(NUM_SLOTS), .NUM_THREADS(NUM_THREADS)) ctrl_i (
    .mtMode(mtMode), .slotValid(slotValid), .slotDone(slotDone),
    .headIdx(headIdx), .tailIdx(tailIdx), .occCnt(occCnt),
    .fetchReq(fetchReq), .fetchTid(fetchTid), .flushReq(flushReq),
    .flushSlot(flushSlot), .modeReq(modeReq),
    .fetchGrant(fetchGrant), .fetchSlot(fetchSlot),
    .commitValid(commitValid), .commitSlot(commitSlot), .commitTid(commitTid),
    .strobes(strobes)
  );

  bwData #(.NUM_SLOTS(NUM_SLOTS), .NUM_THREADS(NUM_THREADS)) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .doneIn(doneIn),
    .mtMode(mtMode), .slotValid(slotValid), .slotDone(slotDone),
    .headIdx(headIdx), .tailIdx(tailIdx), .occCnt(occCnt)
  );
endmodule

// File: rtl/block_window_chk.sv
`timescale 1ns/1ps
module blockWindowChk
  import bwPkg::*;
(
  input logic                                 clk,
  input logic                                 rstN,
  input logic                                 mtMode,
  input logic [WIN_SLOTS-1:0]                 slotValid,
  input logic [WIN_SLOTS-1:0]                 slotDone,
  input logic [WIN_THREADS-1:0][SLOT_W:0]     occCnt,
  input logic                                 fetchReq,
  input logic                                 fetchGrant,
  input logic [SLOT_W-1:0]                    fetchSlot,
  input logic                                 flushReq,
  input logic                                 commitValid,
  input logic [SLOT_W-1:0]                    commitSlot,
  input logic [TID_W-1:0]                     commitTid
);
  localparam int MT_RING = WIN_SLOTS / WIN_THREADS;

  // R4
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchGrant |-> fetchReq);

  // R4
  grant_free_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchGrant |-> !slotValid[fetchSlot]);

  for (genvar t = 0; t < WIN_THREADS; t++) begin : g_occ
    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
      int'(occCnt[t]) <= (mtMode ? MT_RING : WIN_SLOTS));
  end

  // R6
  commit_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> (slotValid[commitSlot] && slotDone[commitSlot]));

  // R6
  commit_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |=> !(commitValid && commitSlot == $past(commitSlot)));

  // R3
  commit_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && mtMode) |-> (int'(commitTid) == int'(commitSlot) / MT_RING));

  // R2
  commit_st_tid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && !mtMode) |-> (commitTid == '0));

  // R9
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> (!fetchGrant && !commitValid));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|slotValid) |=> $stable(mtMode));
endmodule

bind blockWindow blockWindowChk chk_i (
  .clk(clk), .rstN(rstN), .mtMode(mtMode), .slotValid(slotValid),
  .slotDone(slotDone), .occCnt(occCnt), .fetchReq(fetchReq),
  .fetchGrant(fetchGrant), .fetchSlot(fetchSlot), .flushReq(flushReq),
  .commitValid(commitValid), .commitSlot(commitSlot), .commitTid(commitTid)
);

// File: tb/block_window_tb.sv
`timescale 1ns/1ps
module blockWindow_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeReq = 1'b0;
  logic fetchReq = 1'b0;
  logic [1:0] fetchTid = '0;
  logic fetchGrant;
  logic [2:0] fetchSlot;
  logic [7:0] doneIn = '0;
  logic flushReq = 1'b0;
  logic [2:0] flushSlot = '0;
  logic commitValid;
  logic [2:0] commitSlot;
  logic [1:0] commitTid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state
  bit mMt;
  int mHead[4], mTail[4], mCnt[4];
  bit mValid[8], mDone[8];

  always #5 clk = ~clk;

  blockWindow dut_i (
    .clk(clk), .rstN(rstN), .modeReq(modeReq), .fetchReq(fetchReq),
    .fetchTid(fetchTid), .fetchGrant(fetchGrant), .fetchSlot(fetchSlot),
    .doneIn(doneIn), .flushReq(flushReq), .flushSlot(flushSlot),
    .commitValid(commitValid), .commitSlot(commitSlot), .commitTid(commitTid)
  );

  function automatic int rsz();
    return mMt ? 2 : 8;
  endfunction

  function automatic int baseT(int t);
    return mMt ? t * 2 : 0;
  endfunction

  function automatic bit modelEmpty();
    for (int s = 0; s < 8; s++) if (mValid[s]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mMt = 1'b0;
    for (int t = 0; t < 4; t++) begin mHead[t] = 0; mTail[t] = 0; mCnt[t] = 0; end
    for (int s = 0; s < 8; s++) begin mValid[s] = 1'b0; mDone[s] = 1'b0; end
  endtask

  // one cycle: drive, check outputs against the model, advance the model
  task automatic cyc(bit fr, int ft, bit [7:0] dn, bit fl, int fs, bit md, string tag);
    bit expG, expC, found;
    int expS, cS, cT, r;
    string gTag, sTag, cTag;
    @(negedge clk);
    fetchReq = fr; fetchTid = 2'(ft); doneIn = dn;
    flushReq = fl; flushSlot = 3'(fs); modeReq = md;
    #2;
    r = rsz();
    expG = fr && !fl && (mMt || ft == 0) && (mCnt[ft] < r);
    expS = baseT(ft) + mTail[ft];
    found = 1'b0; cS = 0; cT = 0;
    for (int t = 0; t < 4; t++) begin
      if (!found && mCnt[t] > 0 && mDone[baseT(t) + mHead[t]]) begin
        found = 1'b1; cS = baseT(t) + mHead[t]; cT = t;
      end
    end
    expC = found && !fl;
    gTag = (tag != "") ? tag : fl ? "R9" : (!mMt && ft != 0) ? "R2" : "R4";
    sTag = (tag != "") ? tag : mMt ? "R3" : "R2";
    cTag = (tag != "") ? tag : fl ? "R9" : "R6";
    if (fr) chk(gTag, "fetchGrant", int'(fetchGrant), int'(expG));
    if (expG && fetchGrant) chk(sTag, "fetchSlot", int'(fetchSlot), expS);
    chk(cTag, "commitValid", int'(commitValid), int'(expC));
    if (expC && commitValid) begin
      chk(cTag, "commitSlot", int'(commitSlot), cS);
      chk((tag != "") ? tag : "R7", "commitTid", int'(commitTid), cT);
    end
    // model update at the coming edge
    if (modelEmpty() && !fr && md != mMt) begin
      mMt = md;
      for (int t = 0; t < 4; t++) begin mHead[t] = 0; mTail[t] = 0; mCnt[t] = 0; end
    end else begin
      for (int s = 0; s < 8; s++) if (dn[s] && mValid[s]) mDone[s] = 1'b1;
      if (expC) begin
        mValid[cS] = 1'b0; mDone[cS] = 1'b0;
        mHead[cT] = (mHead[cT] + 1) % r; mCnt[cT]--;
      end
      if (expG) begin
        mValid[expS] = 1'b1; mDone[expS] = 1'b0;
        mTail[ft] = (mTail[ft] + 1) % r; mCnt[ft]++;
      end
      if (fl && mValid[fs]) begin
        int t, idx, keep;
        t = mMt ? fs / 2 : 0;
        idx = fs - baseT(t);
        keep = (idx - mHead[t] + r) % r;
        for (int k = 0; k < r; k++) begin
          int sl;
          sl = baseT(t) + k;
          if (mValid[sl] && ((k - mHead[t] + r) % r) > keep) begin
            mValid[sl] = 1'b0; mDone[sl] = 1'b0;
          end
        end
        mTail[t] = (idx + 1) % r;
        mCnt[t] = keep + 1;
      end
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && !modelEmpty(); i++) cyc(0, 0, 8'hFF, 0, 0, mMt, "");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #2;
    chk("R1", "commitValid after reset", int'(commitValid), 0);
    cyc(1, 0, 0, 0, 0, 0, "R1");                 // slot 0
    cyc(1, 1, 0, 0, 0, 0, "R2");                 // thread 1 refused
    for (int i = 1; i < 8; i++) cyc(1, 0, 0, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, 0, 0, "R4");                 // ring full
    cyc(0, 0, 8'h08, 0, 0, 0, "R6");             // younger done first
    cyc(0, 0, 0, 0, 0, 0, "R6");                 // no retire yet
    cyc(0, 0, 8'h01, 0, 0, 0, "R6");
    cyc(0, 0, 8'h06, 0, 0, 0, "R6");             // slot 0 retires
    cyc(0, 0, 0, 0, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 0, "R6");
    cyc(0, 0, 0, 0, 5, 0, "R8");
    cyc(0, 0, 0, 1, 5, 0, "R8");                 // kill 6,7
    cyc(1, 0, 0, 0, 0, 0, "R8");                 // takes slot 6
    cyc(1, 0, 0, 1, 6, 0, "R9");                 // flush beats fetch
    cyc(1, 0, 0, 1, 1, 0, "R8");                 // slot 1 empty: ignored
    cyc(1, 0, 0, 0, 0, 1, "R10");                // mode request while busy
    cyc(1, 0, 0, 0, 0, 1, "R10");
    drain();
    cyc(1, 0, 0, 0, 0, 1, "R10");                // fetch pending: still no load
    drain();
    cyc(0, 0, 0, 0, 0, 1, "R10");                // loads multithreaded
    cyc(1, 2, 0, 0, 0, 1, "R3");
    cyc(1, 2, 0, 0, 0, 1, "R3");
    cyc(1, 2, 0, 0, 0, 1, "R4");
    cyc(1, 0, 0, 0, 0, 1, "R3");
    cyc(1, 1, 0, 0, 0, 1, "R3");
    cyc(0, 0, 8'h15, 0, 0, 1, "R7");
    cyc(0, 0, 0, 0, 0, 1, "R7");
    cyc(0, 0, 0, 0, 0, 1, "R7");
    cyc(0, 0, 0, 0, 0, 1, "R7");
    cyc(0, 0, 8'h40, 0, 0, 1, "R5");             // slot 6 empty
    cyc(1, 3, 0, 0, 0, 1, "R5");
    cyc(0, 0, 0, 0, 0, 1, "R5");
    cyc(0, 0, 0, 0, 0, 1, "R5");
    for (int i = 0; i < 4000; i++) begin
      bit [7:0] dn;
      int ft;
      if (i % 300 == 299) begin
        drain();
        cyc(0, 0, 0, 0, 0, ~mMt, "");
      end
      dn = 8'($urandom) & 8'($urandom) & 8'($urandom);
      ft = mMt ? int'($urandom % 4) : (($urandom % 8 == 0) ? 1 : 0);
      cyc(($urandom % 3) != 0, ft, dn, ($urandom % 25) == 0,
          int'($urandom % 8), mMt, "");
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule